// File: doc/BRIEF.md
# Special Register Hazard Stall Unit

This unit sits at the issue stage of a simple in-order pipeline. It compares each instruction waiting to issue with the instruction that issued in the cycle before. When the waiting instruction reads a special register that its direct predecessor has just changed, the unit raises a stall and holds the instruction back. Each cycle of the stall sends a bubble downstream.

The predecessor is recorded by three flags. The first marks an explicit write into the special register space. The second marks an implicit update of the condition flags. The third marks an explicit write of the stack pointer. The waiting instruction is described by three flags as well: a read of any special register, a read of the status word, and an implicit increment or decrement of the stack pointer.

Each hazard class has its own penalty, set by a parameter. A generic write followed by a read costs one cycle. A flag update followed by a status word read costs two cycles, and so does a stack pointer write followed by an implicit adjust. Any other instruction between the pair removes the hazard, and so does a bubble.

Top module: `sfr_stall_unit`

## Requirements
- R1: With default parameters, if the issued predecessor set `prv_sfr_wr` and the waiting instruction sets `nxt_sfr_rd` or `nxt_psw_rd`, `stall` is high for at least one cycle before that instruction issues. A status word read counts as a special register read.
- R2: If the predecessor set `prv_flag_upd` and the waiting instruction sets `nxt_psw_rd`, `stall` is high for two consecutive cycles.
- R3: If the predecessor set `prv_sp_wr` and the waiting instruction sets `nxt_sp_adj`, `stall` is high for two consecutive cycles.
- R4: Any combination of predecessor and waiting flags that matches none of R1 to R3 issues with no stall cycle.
- R5: A hazard is only seen between directly adjacent issued instructions. If an invalid cycle (`in_valid` low) or an issued instruction with no flags set comes between the pair, there is no stall.
- R6: When several classes match at once, the number of stall cycles is the largest matching penalty, never their sum. With defaults this is at most 2.
- R7: While `stall` is high, `issue` is low and the waiting instruction is held. In the cycle after the last stall cycle, that instruction issues with `issue` high.
- R8: A cycle with `in_valid` low never issues, and it leaves no history behind that could cause a later stall.
- R9: During reset `issue` and `stall` are low. The first instruction after reset issues with no stall, whatever its read flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is waiting at the issue stage |
| prv_sfr_wr | input | 1 | Waiting instruction writes the special register space (recorded as history once it issues) |
| prv_flag_upd | input | 1 | Waiting instruction updates the condition flags implicitly |
| prv_sp_wr | input | 1 | Waiting instruction writes the stack pointer explicitly |
| nxt_sfr_rd | input | 1 | Waiting instruction reads a special register |
| nxt_psw_rd | input | 1 | Waiting instruction reads the status word |
| nxt_sp_adj | input | 1 | Waiting instruction increments or decrements the stack pointer implicitly |
| stall | output | 1 | Hold the issue stage this cycle |
| issue | output | 1 | The waiting instruction issues this cycle; low means a bubble goes downstream |

## Verification
The stall decision is combinational against the registered history. For a hazard, `stall` is therefore already high in the cycle the dependent instruction is first presented, and `issue` rises exactly penalty cycles later. The bench drives inputs on the falling edge and samples outputs a quarter period later, before the next rising edge, so each sample shows the current cycle's decision. It counts stall cycles until `issue` rises and compares the count with the largest matching penalty. It sweeps all 64 combinations of predecessor and waiting flags, and runs each one with the pair adjacent, separated by a bubble, and separated by an instruction with no flags.

// File: rtl/sfr_stall_unit.sv
module sfr_stall_unit #(
  parameter int PEN_SFR  = 1,
  parameter int PEN_FLAG = 2,
  parameter int PEN_SP   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic prv_sfr_wr,
  input  logic prv_flag_upd,
  input  logic prv_sp_wr,
  input  logic nxt_sfr_rd,
  input  logic nxt_psw_rd,
  input  logic nxt_sp_adj,
  output logic stall,
  output logic issue
);

  localparam int PMAX_A = (PEN_SFR > PEN_FLAG) ? PEN_SFR : PEN_FLAG;
  localparam int PMAX   = (PMAX_A > PEN_SP) ? PMAX_A : PEN_SP;
  localparam int CW     = $clog2(PMAX + 1);

  logic          h_sfr, h_flag, h_sp;
  logic [CW-1:0] wait_q;
  logic [CW-1:0] p_sfr, p_flag, p_sp, p_ab, pen;
  logic          start;

  assign p_sfr  = (h_sfr  && (nxt_sfr_rd || nxt_psw_rd)) ? CW'(PEN_SFR)  : '0;
  assign p_flag = (h_flag && nxt_psw_rd)                  ? CW'(PEN_FLAG) : '0;
  assign p_sp   = (h_sp   && nxt_sp_adj)                  ? CW'(PEN_SP)   : '0;
  assign p_ab   = (p_sfr > p_flag) ? p_sfr : p_flag;
  assign pen    = (p_ab > p_sp) ? p_ab : p_sp;

  assign start = rst_n && in_valid && (wait_q == '0) && (pen != '0);
  assign stall = rst_n && ((wait_q != '0) || start);
  assign issue = rst_n && in_valid && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_sfr  <= 1'b0;
      h_flag <= 1'b0;
      h_sp   <= 1'b0;
      wait_q <= '0;
    end else begin
      h_sfr  <= issue && prv_sfr_wr;
      h_flag <= issue && prv_flag_upd;
      h_sp   <= issue && prv_sp_wr;
      if (start)
        wait_q <= pen - CW'(1);
      else if (wait_q != '0)
        wait_q <= wait_q - CW'(1);
    end
  end

  AST_GENERIC_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (nxt_sfr_rd || nxt_psw_rd) && $past(issue && prv_sfr_wr)) |-> stall); // R1

  AST_FLAG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nxt_psw_rd && $past(issue && prv_flag_upd)) |-> stall); // R2

  AST_FLAG_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nxt_psw_rd && $past(issue && prv_flag_upd)) |=> stall); // R2

  AST_SP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nxt_sp_adj && $past(issue && prv_sp_wr)) |-> stall); // R3

  AST_SP_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nxt_sp_adj && $past(issue && prv_sp_wr)) |=> stall); // R3

  AST_GAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue && !stall) |=> !stall); // R5

  AST_NO_ISSUE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !issue); // R8

  always_ff @(posedge clk)
    if (rst_n) AST_WAIT_BOUND: assert (wait_q < CW'(PMAX)); // R6

endmodule

// File: tb/sfr_stall_unit_tb.sv
module sfr_stall_unit_tb;
  logic clk = 1'b0;
  logic rst_n, in_valid;
  logic prv_sfr_wr, prv_flag_upd, prv_sp_wr;
  logic nxt_sfr_rd, nxt_psw_rd, nxt_sp_adj;
  logic stall, issue;
  int   tests = 0;
  int   fails = 0;

  always #10 clk = ~clk;

  sfr_stall_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .prv_sfr_wr(prv_sfr_wr), .prv_flag_upd(prv_flag_upd), .prv_sp_wr(prv_sp_wr),
    .nxt_sfr_rd(nxt_sfr_rd), .nxt_psw_rd(nxt_psw_rd), .nxt_sp_adj(nxt_sp_adj),
    .stall(stall), .issue(issue)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] w, input logic [2:0] r);
    in_valid     = v;
    prv_sfr_wr   = w[0];
    prv_flag_upd = w[1];
    prv_sp_wr    = w[2];
    nxt_sfr_rd   = r[0];
    nxt_psw_rd   = r[1];
    nxt_sp_adj   = r[2];
  endtask

  function automatic int expect_pen(input logic [2:0] w, input logic [2:0] r);
    int e = 0;
    if (w[0] && (r[0] || r[1]) && e < 1) e = 1;
    if (w[1] && r[1] && e < 2) e = 2;
    if (w[2] && r[2] && e < 2) e = 2;
    return e;
  endfunction

  task automatic run_case(input logic [2:0] w, input logic [2:0] r, input int gap);
    int cnt = 0;
    int overlap = 0;
    int exp;
    string tag;
    @(negedge clk); drive(1'b0, 3'b000, 3'b000);
    #5 chk("R8 idle no issue", int'(issue), 0);
    @(negedge clk); drive(1'b1, w, 3'b000);
    #5 chk("R4 predecessor issues", int'(issue), 1);
    if (gap == 1) begin
      @(negedge clk); drive(1'b0, 3'b000, 3'b000);
    end else if (gap == 2) begin
      @(negedge clk); drive(1'b1, 3'b000, 3'b000);
    end
    @(negedge clk); drive(1'b1, 3'b000, r);
    for (int k = 0; k < 8; k++) begin
      #5;
      if (stall && issue) overlap++;
      if (issue) break;
      if (stall) cnt++;
      @(negedge clk);
    end
    exp = (gap == 0) ? expect_pen(w, r) : 0;
    if (gap != 0)
      tag = "R5 separated pair";
    else if (exp == 0)
      tag = "R4 no hazard";
    else if (w[1] && r[1] && w[0])
      tag = "R6 largest penalty";
    else if (w[1] && r[1])
      tag = "R2 flag to status";
    else if (w[2] && r[2])
      tag = "R3 stack pointer";
    else
      tag = "R1 generic";
    chk(tag, cnt, exp);
    chk("R7 issue after stall", int'(issue), 1);
    chk("R7 no issue while stalled", overlap, 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 3'b111, 3'b111);
    @(negedge clk); @(negedge clk);
    #5;
    chk("R9 reset stall", int'(stall), 0);
    chk("R9 reset issue", int'(issue), 0);
    @(negedge clk); rst_n = 1'b1; drive(1'b1, 3'b000, 3'b111);
    #5;
    chk("R9 first after reset stall", int'(stall), 0);
    chk("R9 first after reset issue", int'(issue), 1);
    for (int g = 0; g < 3; g++)
      for (int wi = 0; wi < 8; wi++)
        for (int ri = 0; ri < 8; ri++)
          run_case(3'(wi), 3'(ri), g);
    @(negedge clk); drive(1'b0, 3'b000, 3'b000);
    #5 chk("R8 invalid no stall", int'(stall), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule